// File: doc/BRIEF.md
# Externally Clocked Serial Shift Port

This block is a serial port with one receive and one transmit shift register. Both registers are clocked by a serial clock that comes from outside the chip and runs much slower than the core clock. The serial clock and the two shift enables are brought into the core clock domain through two-flop synchronisers. An edge detector then produces one-cycle strobes for the rising and falling serial-clock edges. Received bits are taken on rising edges and transmitted bits advance on falling edges. Each direction shifts only while its own enable is high.

Each direction is set to 8-bit or 16-bit words on its own. An 8-bit word uses only the low byte of the register. The core chooses the transmit bit order when it loads a word. It chooses the receive bit order when it reads the captured word. The transmit request stays high from the load until the last bit has been shifted out. The transmitter also drives an output-enable line that controls the serial data pad's tri-state buffer. A done flag is given to the core for each direction.

Top module: `sio_shift_port`

## Requirements
- R1: After reset, `tx_req`, `tx_ack`, `rx_ack` and `tx_oe` are 0, and `rx_word` is 0.
- R2: A receive bit is taken from `rx_sd` only on a rising edge of `sclk` while `rx_en` is high. Rising edges while `rx_en` is low are not counted. A word is complete after 16 bits when `rx_wide`=1, and after 8 bits when `rx_wide`=0.
- R3: With `rx_reverse`=0, `rx_word` holds the first received bit in its top position: bit 15 in 16-bit mode, bit 7 in 8-bit mode. In 8-bit mode bits 15..8 read as 0.
- R4: With `rx_reverse`=1, `rx_word` holds the same word bit-reversed within its length, so the first received bit is at bit 0. In 8-bit mode bits 15..8 read as 0.
- R5: `rx_ack` goes to 1 when a word completes. It returns to 0 after a one-cycle `rx_read` pulse.
- R6: A `tx_load` pulse sets `tx_req` to 1 and `tx_ack` to 0. After 16 enabled falling edges of `sclk` (8 when `tx_wide`=0 at load time), `tx_req` goes to 0 and `tx_ack` goes to 1.
- R7: With `tx_lsb_first`=0 at load, `tx_sd` presents the word from bit (length-1) down to bit 0. Each bit is stable across the rising edge that follows it.
- R8: With `tx_lsb_first`=1 at load, `tx_sd` presents the word from bit 0 up to bit (length-1).
- R9: `tx_oe` follows `tx_en`. While `tx_en` is low, falling edges of `sclk` do not advance the transmit word. When `tx_en` returns high, the word resumes at the bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock, at least 4x the serial clock rate |
| rst_n | input | 1 | active-low reset |
| sclk | input | 1 | external serial clock |
| rx_en | input | 1 | receive shift enable |
| rx_sd | input | 1 | serial receive data |
| tx_en | input | 1 | transmit shift enable |
| tx_sd | output | 1 | serial transmit data (valid while tx_oe is high) |
| tx_oe | output | 1 | tri-state enable for the tx_sd pad |
| tx_req | output | 1 | a transmit word is waiting or being shifted |
| rx_wide | input | 1 | 1 = 16-bit receive words, 0 = 8-bit |
| tx_wide | input | 1 | 1 = 16-bit transmit words, 0 = 8-bit |
| tx_load | input | 1 | one-cycle strobe that loads tx_word |
| tx_lsb_first | input | 1 | bit order for the word being loaded |
| tx_word | input | 16 | transmit word from the core |
| tx_ack | output | 1 | set when a transmit word has been fully sent |
| rx_read | input | 1 | one-cycle strobe that consumes the received word |
| rx_reverse | input | 1 | selects the bit-reversed view of the received word |
| rx_word | output | 16 | received word |
| rx_ack | output | 1 | a received word is waiting |

## Verification
Any change on `sclk` or on an enable reaches the logic two core cycles later. The shift or flag update it causes then registers on the third cycle. The bench therefore holds every serial-clock level for four core cycles and drives and samples on the falling core-clock edge. Each transmit bit is read at the instant the bench raises `sclk`, which is at least four cycles after the falling edge that put that bit on the line. Flags and received words are checked only after a full half period has passed since the edge that should have set them.

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            rx_en,
  input  logic            rx_sd,
  input  logic            tx_en,
  output logic            tx_sd,
  output logic            tx_oe,
  output logic            tx_req,
  input  logic            rx_wide,
  input  logic            tx_wide,
  input  logic            tx_load,
  input  logic            tx_lsb_first,
  input  logic [WORD-1:0] tx_word,
  output logic            tx_ack,
  input  logic            rx_read,
  input  logic            rx_reverse,
  output logic [WORD-1:0] rx_word,
  output logic            rx_ack
);
  localparam int HALF = WORD / 2;
  localparam int CW   = $clog2(WORD + 1);
  localparam int IW   = $clog2(WORD);
  localparam logic [CW-1:0] LAST_W = CW'(WORD - 1);
  localparam logic [CW-1:0] LAST_H = CW'(HALF - 1);

  logic [2:0] sck_q;
  logic [1:0] rxe_q, txe_q, rxd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; rxe_q <= '0; txe_q <= '0; rxd_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      rxe_q <= {rxe_q[0], rx_en};
      txe_q <= {txe_q[0], tx_en};
      rxd_q <= {rxd_q[0], rx_sd};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire rx_on    = rxe_q[1];
  assign tx_oe  = txe_q[1];

  logic [WORD-1:0] rx_sr, rx_hold, rev_w, rev_h;
  logic [CW-1:0]   rx_cnt;
  wire             rx_shift = sck_rise & rx_on;
  wire             rx_done  = rx_shift & (rx_cnt == (rx_wide ? LAST_W : LAST_H));
  wire [WORD-1:0]  rx_next  = {rx_sr[WORD-2:0], rxd_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr <= '0; rx_hold <= '0; rx_cnt <= '0; rx_ack <= 1'b0;
    end else begin
      if (rx_shift) begin
        rx_sr  <= rx_next;
        rx_cnt <= rx_done ? '0 : rx_cnt + 1'b1;
      end
      if (rx_done) begin
        rx_hold <= rx_wide ? rx_next : {{HALF{1'b0}}, rx_next[HALF-1:0]};
        rx_ack  <= 1'b1;
      end else if (rx_read) begin
        rx_ack  <= 1'b0;
      end
    end

  for (genvar i = 0; i < WORD; i++) begin : g_rev
    assign rev_w[i] = rx_hold[WORD-1-i];
    if (i < HALF) begin : g_lo
      assign rev_h[i] = rx_hold[HALF-1-i];
    end else begin : g_hi
      assign rev_h[i] = 1'b0;
    end
  end

  assign rx_word = !rx_reverse ? rx_hold : (rx_wide ? rev_w : rev_h);

  logic [WORD-1:0] tx_q;
  logic            tx_lsb_q, tx_wide_q;
  logic [CW-1:0]   tx_cnt;
  wire  [CW-1:0]   tx_last = tx_wide_q ? LAST_W : LAST_H;
  wire  [CW-1:0]   tx_idx  = tx_lsb_q ? tx_cnt : tx_last - tx_cnt;
  wire             tx_step = sck_fall & tx_oe & tx_req;

  assign tx_sd = tx_req & tx_q[tx_idx[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_q <= '0; tx_lsb_q <= 1'b0; tx_wide_q <= 1'b1;
      tx_cnt <= '0; tx_req <= 1'b0; tx_ack <= 1'b0;
    end else if (tx_load) begin
      tx_q      <= tx_word;
      tx_lsb_q  <= tx_lsb_first;
      tx_wide_q <= tx_wide;
      tx_cnt    <= '0;
      tx_req    <= 1'b1;
      tx_ack    <= 1'b0;
    end else if (tx_step) begin
      if (tx_cnt == tx_last) begin
        tx_cnt <= '0;
        tx_req <= 1'b0;
        tx_ack <= 1'b1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
endmodule

module sio_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_load,
  input logic tx_req,
  input logic tx_ack,
  input logic tx_oe,
  input logic tx_sd,
  input logic rx_read,
  input logic rx_ack,
  input logic rx_done,
  input logic rx_on
);
  p_load_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_req && !tx_ack));
  p_req_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !tx_ack);
  p_fall_req_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req) |-> tx_ack);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !rx_done) |=> !rx_ack);
  p_ack_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past(rx_on));
  p_pause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_oe && !tx_load) |=> ($stable(tx_sd) && $stable(tx_req)));
endmodule

bind sio_shift_port sio_shift_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_req(tx_req),
  .tx_ack(tx_ack), .tx_oe(tx_oe), .tx_sd(tx_sd), .rx_read(rx_read),
  .rx_ack(rx_ack), .rx_done(rx_done), .rx_on(rx_on)
);

// File: tb/test_sio_shift_port.sv
module test_sio_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, rx_en = 1'b0, rx_sd = 1'b0, tx_en = 1'b0;
  logic rx_wide = 1'b1, tx_wide = 1'b1, tx_load = 1'b0, tx_lsb_first = 1'b0;
  logic [15:0] tx_word = '0;
  logic rx_read = 1'b0, rx_reverse = 1'b0;
  logic tx_sd, tx_oe, tx_req, tx_ack, rx_ack;
  logic [15:0] rx_word;

  int vecs = 0, errs = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_shift_port i_sio_shift_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rx_en(rx_en), .rx_sd(rx_sd),
    .tx_en(tx_en), .tx_sd(tx_sd), .tx_oe(tx_oe), .tx_req(tx_req),
    .rx_wide(rx_wide), .tx_wide(tx_wide), .tx_load(tx_load),
    .tx_lsb_first(tx_lsb_first), .tx_word(tx_word), .tx_ack(tx_ack),
    .rx_read(rx_read), .rx_reverse(rx_reverse), .rx_word(rx_word),
    .rx_ack(rx_ack)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string tag, input logic [15:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [15:0] act);
    logic [15:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    vecs++;
    if (act !== e) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] e);
    expect_val(tag, e);
    observe(act);
  endtask

  function automatic logic [15:0] rev(input logic [15:0] w, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = w[n-1-i];
    return r;
  endfunction

  task automatic rx_send(input logic [15:0] w, input int n);
    for (int k = n-1; k >= 0; k--) begin
      rx_sd = w[k];
      wait_n(HOLD);
      sclk = 1'b1;
      wait_n(HOLD);
      sclk = 1'b0;
    end
    wait_n(HOLD);
  endtask

  task automatic tx_start(input logic [15:0] w, input logic wide, input logic lsb);
    tx_word = w; tx_wide = wide; tx_lsb_first = lsb; tx_load = 1'b1;
    wait_n(1);
    tx_load = 1'b0;
    wait_n(1);
  endtask

  task automatic tx_clock(input int n, inout logic [15:0] got, inout int pos);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b1;
      got[pos] = tx_sd;
      pos++;
      wait_n(HOLD);
      sclk = 1'b0;
      wait_n(HOLD);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int pos;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    check("R1 flags", {12'd0, tx_req, tx_ack, rx_ack, tx_oe}, 16'h0);
    check("R1 rx_word", rx_word, 16'h0);

    // R2/R3/R4/R5 16-bit receive
    rx_en = 1'b1; rx_wide = 1'b1;
    wait_n(HOLD);
    rx_send(16'hA35C, 16);
    check("R5 rx_ack set", {15'd0, rx_ack}, 16'h1);
    check("R3 normal 16", rx_word, 16'hA35C);
    rx_reverse = 1'b1;
    wait_n(1);
    check("R4 reversed 16", rx_word, rev(16'hA35C, 16));
    rx_read = 1'b1; wait_n(1); rx_read = 1'b0; wait_n(1);
    check("R5 rx_ack cleared", {15'd0, rx_ack}, 16'h0);

    // R2 8-bit receive
    rx_wide = 1'b0; rx_reverse = 1'b0;
    rx_send(16'h00B4, 8);
    check("R2 8-bit completes", {15'd0, rx_ack}, 16'h1);
    check("R3 normal 8", rx_word, 16'h00B4);
    rx_reverse = 1'b1;
    wait_n(1);
    check("R4 reversed 8", rx_word, 16'h002D);
    rx_read = 1'b1; wait_n(1); rx_read = 1'b0; wait_n(1);

    // R2 gated edges are not counted
    rx_en = 1'b0; rx_reverse = 1'b0;
    wait_n(HOLD);
    rx_send(16'h0007, 3);
    check("R2 gated no ack", {15'd0, rx_ack}, 16'h0);
    rx_en = 1'b1;
    wait_n(HOLD);
    rx_send(16'h003C, 8);
    check("R2 gated word intact", rx_word, 16'h003C);
    rx_read = 1'b1; wait_n(1); rx_read = 1'b0;
    rx_en = 1'b0;
    wait_n(HOLD);

    // R6/R7 16-bit msb first
    tx_start(16'hC3A5, 1'b1, 1'b0);
    check("R6 req after load", {14'd0, tx_req, tx_ack}, 16'h2);
    tx_en = 1'b1;
    wait_n(HOLD);
    check("R9 oe follows enable", {15'd0, tx_oe}, 16'h1);
    got = '0; pos = 0;
    tx_clock(16, got, pos);
    check("R7 msb first 16", rev(got, 16), 16'hC3A5);
    check("R6 done flags", {14'd0, tx_req, tx_ack}, 16'h1);

    // R8 8-bit lsb first
    tx_start(16'h006B, 1'b0, 1'b1);
    check("R6 load clears ack", {14'd0, tx_req, tx_ack}, 16'h2);
    got = '0; pos = 0;
    tx_clock(8, got, pos);
    check("R8 lsb first 8", got, 16'h006B);
    check("R6 8-bit done", {14'd0, tx_req, tx_ack}, 16'h1);

    // R9 pause mid-word
    tx_start(16'h1E2D, 1'b1, 1'b1);
    got = '0; pos = 0;
    tx_clock(5, got, pos);
    tx_en = 1'b0;
    wait_n(HOLD);
    check("R9 oe released", {15'd0, tx_oe}, 16'h0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wait_n(HOLD); sclk = 1'b0; wait_n(HOLD);
    end
    check("R9 still pending", {14'd0, tx_req, tx_ack}, 16'h2);
    tx_en = 1'b1;
    wait_n(HOLD);
    tx_clock(11, got, pos);
    check("R9 resumed word", got, 16'h1E2D);
    check("R9 done after resume", {14'd0, tx_req, tx_ack}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule